// File: doc/BRIEF.md
# Partial-Tag Branch Target Buffer

This block guesses where fetch goes next. A set-associative table keeps one entry for each taken branch it has seen. An entry holds a valid flag, a shortened slice of the branch address used as its tag, and only the low-order bits of the branch destination. On every cycle the lookup side receives a fetch PC and answers combinationally, within that cycle. It returns a hit flag and a next-fetch address. On a hit the address is the upper bits of the fetch PC joined to the stored low target bits. On a miss it is the sequential address PC+4.

The update side receives a resolved taken branch together with its full destination. If the tag is already present in the set, that entry is refreshed in place. Otherwise the first empty way is filled. When the set is full, a round-robin pointer kept for each set picks the way to replace. A synchronous flush invalidates the whole table in one cycle. Shortening the tags and the targets saves storage. In exchange, the table will hit for an aliased address and will predict wrongly when the real destination lies outside the window of the current PC. Catching and correcting those wrong predictions is left to the pipeline.

With default parameters there are 16 sets and 4 ways. The set index is PC[5:2], the tag is PC[13:6], and the stored target is bits [11:0] of the destination.

Top module: `btb_partial`

## Requirements
- R1: A reset clears every entry and every replacement pointer. On the first cycle after reset a lookup misses.
- R2: After an update of branch PC P with destination T, a lookup of P on the following cycle hits. Its next address is {P[31:12], T[11:0]}.
- R3: On a miss, lk_hit is 0 and lk_next_pc equals lk_pc + 4.
- R4: The compare uses only tag bits PC[13:6] and index bits PC[5:2]. A lookup PC that equals a stored branch in those bits but differs in PC[31:14] still hits. The same index with a different tag misses.
- R5: The upper bits [31:12] of the predicted address always come from the lookup PC, never from the stored destination, so a far destination is mispredicted.
- R6: An update whose tag is already present in its set overwrites the target of that way. It does not consume another way, and the other entries in the set keep their contents.
- R7: An update that misses in its set fills the lowest-numbered invalid way before any valid entry is replaced. Four distinct tags in one set all stay resident.
- R8: An update to a full set with no tag match replaces the way named by that set's round-robin pointer, starting from way 0 after reset. The pointer advances by one, wrapping, only on such a replacement.
- R9: Asserting flush invalidates all entries at the next clock edge. An update presented in the same cycle as flush is discarded.
- R10: A lookup in the same cycle as an update to the same set sees the table contents from before that update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| flush | input | 1 | Invalidate all entries at the next edge |
| lk_pc | input | 32 | Fetch PC to look up |
| lk_hit | output | 1 | Lookup found a valid entry with a matching tag |
| lk_next_pc | output | 32 | Predicted next fetch address |
| upd_valid | input | 1 | Install or refresh a taken branch this cycle |
| upd_pc | input | 32 | Address of the resolved taken branch |
| upd_target | input | 32 | Full destination of that branch |

## Verification
The bound checker watches four rules on every cycle. A miss returns PC+4. A hit takes its upper address bits from the lookup PC. A lookup the cycle after an update of the same PC hits with the stored low target bits. The table is empty right after reset or flush. The choice of victim cannot be seen on any single cycle, and neither can the ordering between refreshes and replacements, aliasing through the shortened tag, or reading old contents during a same-cycle write. Only the bench's directed sequences, which fill, refresh and overflow one set and then probe each entry, show those.

// File: rtl/btb_pkg.sv
package btb_pkg;
    // byte offset bits below the instruction granule, skipped by the index
    localparam int unsigned BTB_ALIGN = 2;

    function automatic int unsigned wrap_inc(int unsigned v, int unsigned n);
        return (v + 1 >= n) ? 0 : v + 1;
    endfunction
endpackage

// File: rtl/btb_set_match.sv
module btb_set_match #(
    parameter int unsigned WAYS  = 4,
    parameter int unsigned TAG_W = 8
) (
    input  logic [WAYS-1:0]            vld,
    input  logic [WAYS-1:0][TAG_W-1:0] tags,
    input  logic [TAG_W-1:0]           key,
    output logic [WAYS-1:0]            hitv
);
    // one comparator per way, all in parallel
    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign hitv[w] = vld[w] && (tags[w] == key);
    end
endmodule

// File: rtl/btb_victim.sv
module btb_victim #(
    parameter int unsigned WAYS  = 4,
    parameter int unsigned WAY_W = 2
) (
    input  logic [WAYS-1:0]  hitv,
    input  logic [WAYS-1:0]  vld,
    input  logic [WAY_W-1:0] rr_ptr,
    output logic [WAY_W-1:0] way,
    output logic             use_rr
);
    logic             any_hit;
    logic             any_free;
    logic [WAY_W-1:0] hit_way;
    logic [WAY_W-1:0] free_way;

    always_comb begin
        any_hit  = 1'b0;
        any_free = 1'b0;
        hit_way  = '0;
        free_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (hitv[w]) begin
                any_hit = 1'b1;
                hit_way = WAY_W'(w);
            end
            if (!vld[w]) begin
                any_free = 1'b1;
                free_way = WAY_W'(w);
            end
        end
        use_rr = 1'b0;
        if (any_hit) begin
            way = hit_way;
        end else if (any_free) begin
            way = free_way;
        end else begin
            way    = rr_ptr;
            use_rr = 1'b1;
        end
    end
endmodule

// File: rtl/btb_partial.sv
module btb_partial #(
    parameter int unsigned PC_W  = 32,
    parameter int unsigned SETS  = 16,
    parameter int unsigned WAYS  = 4,
    parameter int unsigned TAG_W = 8,
    parameter int unsigned TGT_W = 12
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            flush,
    input  logic [PC_W-1:0] lk_pc,
    output logic            lk_hit,
    output logic [PC_W-1:0] lk_next_pc,
    input  logic            upd_valid,
    input  logic [PC_W-1:0] upd_pc,
    input  logic [PC_W-1:0] upd_target
);
    import btb_pkg::*;

    localparam int unsigned IDX_W = (SETS > 1) ? $clog2(SETS) : 1;
    localparam int unsigned WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;
    localparam int unsigned TAG_LO = BTB_ALIGN + IDX_W;

    typedef struct packed {
        logic [SETS-1:0][WAYS-1:0]            vld;
        logic [SETS-1:0][WAYS-1:0][TAG_W-1:0] tag;
        logic [SETS-1:0][WAYS-1:0][TGT_W-1:0] tgt;
        logic [SETS-1:0][WAY_W-1:0]           rr;
    } btb_state_t;

    btb_state_t st_d, st_q;

    // ---------------- lookup side (reads registered state) ----------------
    logic [IDX_W-1:0] lk_idx;
    logic [TAG_W-1:0] lk_tag;
    logic [WAYS-1:0]  lk_hitv;
    logic [TGT_W-1:0] lk_low;

    assign lk_idx = lk_pc[BTB_ALIGN +: IDX_W];
    assign lk_tag = lk_pc[TAG_LO +: TAG_W];

    btb_set_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_lk_match (
        .vld  (st_q.vld[lk_idx]),
        .tags (st_q.tag[lk_idx]),
        .key  (lk_tag),
        .hitv (lk_hitv)
    );

    always_comb begin
        lk_low = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (lk_hitv[w]) lk_low = lk_low | st_q.tgt[lk_idx][w];
        end
        lk_hit = |lk_hitv;
        if (lk_hit) lk_next_pc = {lk_pc[PC_W-1:TGT_W], lk_low};
        else        lk_next_pc = lk_pc + PC_W'(4);
    end

    // ---------------- update side ----------------
    logic [IDX_W-1:0] up_idx;
    logic [TAG_W-1:0] up_tag;
    logic [WAYS-1:0]  up_hitv;
    logic [WAY_W-1:0] up_way;
    logic             up_rr;
    logic             unused_bits;

    assign up_idx      = upd_pc[BTB_ALIGN +: IDX_W];
    assign up_tag      = upd_pc[TAG_LO +: TAG_W];
    assign unused_bits = ^{upd_pc, upd_target};

    btb_set_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_up_match (
        .vld  (st_q.vld[up_idx]),
        .tags (st_q.tag[up_idx]),
        .key  (up_tag),
        .hitv (up_hitv)
    );

    btb_victim #(.WAYS(WAYS), .WAY_W(WAY_W)) u_victim (
        .hitv   (up_hitv),
        .vld    (st_q.vld[up_idx]),
        .rr_ptr (st_q.rr[up_idx]),
        .way    (up_way),
        .use_rr (up_rr)
    );

    always_comb begin
        st_d = st_q;
        if (flush) begin
            st_d.vld = '0;
        end else if (upd_valid) begin
            st_d.vld[up_idx][up_way] = 1'b1;
            st_d.tag[up_idx][up_way] = up_tag;
            st_d.tgt[up_idx][up_way] = upd_target[TGT_W-1:0];
            if (up_rr) begin
                st_d.rr[up_idx] = WAY_W'(wrap_inc(int'(st_q.rr[up_idx]), WAYS));
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/btb_partial_chk.sv
module btb_partial_chk #(
    parameter int unsigned PC_W  = 32,
    parameter int unsigned TGT_W = 12
) (
    input logic            clk,
    input logic            rst_n,
    input logic            flush,
    input logic [PC_W-1:0] lk_pc,
    input logic            lk_hit,
    input logic [PC_W-1:0] lk_next_pc,
    input logic            upd_valid,
    input logic [PC_W-1:0] upd_pc,
    input logic [PC_W-1:0] upd_target
);
    assert_empty_after_reset_R1: assert property (@(posedge clk)
        !rst_n |=> !lk_hit);

    assert_hit_after_install_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && !flush) |=> (lk_pc != $past(upd_pc)) ||
            (lk_hit && lk_next_pc[TGT_W-1:0] == $past(upd_target[TGT_W-1:0])));

    assert_miss_sequential_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_hit |-> lk_next_pc == lk_pc + PC_W'(4));

    assert_upper_from_pc_R5: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> lk_next_pc[PC_W-1:TGT_W] == lk_pc[PC_W-1:TGT_W]);

    assert_flush_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !lk_hit);
endmodule

bind btb_partial btb_partial_chk #(.PC_W(PC_W), .TGT_W(TGT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush      (flush),
    .lk_pc      (lk_pc),
    .lk_hit     (lk_hit),
    .lk_next_pc (lk_next_pc),
    .upd_valid  (upd_valid),
    .upd_pc     (upd_pc),
    .upd_target (upd_target)
);

// File: tb/sim_btb_partial.sv
module sim_btb_partial;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush = 1'b0;
    logic [31:0] lk_pc = 32'h0;
    logic        lk_hit;
    logic [31:0] lk_next_pc;
    logic        upd_valid = 1'b0;
    logic [31:0] upd_pc = 32'h0;
    logic [31:0] upd_target = 32'h0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    btb_partial u0 (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .lk_pc(lk_pc), .lk_hit(lk_hit), .lk_next_pc(lk_next_pc),
        .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_target(upd_target)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // drive lookup at a falling edge and sample before the next rising edge
    task automatic probe(string req, logic [31:0] pc, logic hit_exp, logic [31:0] nxt_exp);
        @(negedge clk);
        lk_pc = pc;
        #1;
        check(req, {31'b0, lk_hit}, {31'b0, hit_exp});
        check(req, lk_next_pc, nxt_exp);
    endtask

    task automatic install(logic [31:0] pc, logic [31:0] tgt);
        @(negedge clk);
        upd_valid  = 1'b1;
        upd_pc     = pc;
        upd_target = tgt;
        @(negedge clk);
        upd_valid = 1'b0;
    endtask

    function automatic logic [31:0] set3_pc(int t);
        return 32'h4000 + 32'(t) * 64 + 12;
    endfunction
    function automatic logic [31:0] set3_tgt(int t);
        return 32'h7000_0200 + 32'(t) * 16;
    endfunction
    function automatic logic [31:0] set3_pred(int t);
        return 32'h0000_4200 + 32'(t) * 16;
    endfunction

    task automatic t_reset();
        probe("R1", 32'h1000, 1'b0, 32'h1004);
    endtask

    task automatic t_basic();
        install(32'h1010, 32'h0000_1ABC);
        probe("R2", 32'h1010, 1'b1, 32'h1ABC);
        probe("R3", 32'h1014, 1'b0, 32'h1018);
    endtask

    task automatic t_alias();
        probe("R4 alias", 32'h0001_1010, 1'b1, 32'h0001_1ABC);
        probe("R4 tag differs", 32'h1050, 1'b0, 32'h1054);
    endtask

    task automatic t_far();
        install(32'h2020, 32'h8000_0400);
        probe("R5", 32'h2020, 1'b1, 32'h0000_2400);
    endtask

    task automatic t_fill_refresh_replace();
        for (int t = 1; t <= 4; t++) install(set3_pc(t), set3_tgt(t));
        for (int t = 1; t <= 4; t++) probe("R7", set3_pc(t), 1'b1, set3_pred(t));
        install(set3_pc(2), 32'h7000_0ABC);
        probe("R6 new target", set3_pc(2), 1'b1, 32'h0000_4ABC);
        probe("R6 keep", set3_pc(1), 1'b1, set3_pred(1));
        probe("R6 keep", set3_pc(3), 1'b1, set3_pred(3));
        probe("R6 keep", set3_pc(4), 1'b1, set3_pred(4));
        install(set3_pc(5), set3_tgt(5));
        probe("R8 evict way0", set3_pc(1), 1'b0, set3_pc(1) + 4);
        probe("R8", set3_pc(5), 1'b1, set3_pred(5));
        probe("R8 keep", set3_pc(2), 1'b1, 32'h0000_4ABC);
        install(set3_pc(6), set3_tgt(6));
        probe("R8 evict way1", set3_pc(2), 1'b0, set3_pc(2) + 4);
        probe("R8 keep", set3_pc(3), 1'b1, set3_pred(3));
        probe("R8 keep", set3_pc(4), 1'b1, set3_pred(4));
        probe("R8", set3_pc(6), 1'b1, set3_pred(6));
    endtask

    task automatic t_flush();
        @(negedge clk);
        flush      = 1'b1;
        upd_valid  = 1'b1;
        upd_pc     = 32'h6008;
        upd_target = 32'h0000_6500;
        @(negedge clk);
        flush     = 1'b0;
        upd_valid = 1'b0;
        probe("R9 cleared", 32'h1010, 1'b0, 32'h1014);
        probe("R9 cleared", set3_pc(5), 1'b0, set3_pc(5) + 4);
        probe("R9 update dropped", 32'h6008, 1'b0, 32'h600C);
    endtask

    task automatic t_same_cycle();
        @(negedge clk);
        upd_valid  = 1'b1;
        upd_pc     = 32'h1010;
        upd_target = 32'h0000_1ABC;
        lk_pc      = 32'h1010;
        #1;
        check("R10 empty before", {31'b0, lk_hit}, 32'h0);
        @(negedge clk);
        upd_valid  = 1'b1;
        upd_target = 32'h0000_1DEF;
        #1;
        check("R10 old target", lk_next_pc, 32'h1ABC);
        @(negedge clk);
        upd_valid = 1'b0;
        #1;
        check("R10 after edge", lk_next_pc, 32'h1DEF);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_basic();
        t_alias();
        t_far();
        t_fill_refresh_replace();
        t_flush();
        t_same_cycle();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(5 * 100000);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule